// File: doc/BRIEF.md
# Timer Input Capture Unit

The block takes a snapshot of a free-running counter value when a chosen edge shows up on a trigger line. There are two possible trigger sources: an external capture pin and the output bit of an analog comparator. A control input picks one of them. The chosen level passes through a two-stage synchronizer. After that it can go through an optional majority-free filter, which only changes its output once four consecutive samples agree. Last comes an edge detector that responds to either the rising or the falling transition.

On a detected edge the block does two things. It stores the counter value in its capture register and sets a capture flag. The interrupt request is the flag gated by an enable bit. Software clears the flag by writing a one through a register-style strobe.

The counter, the prescaler and the interrupt controller sit outside the block. The counter reaches the block only as a value input. The filter and the edge detector run on the system clock at every cycle, independent of any prescaler. Captures are suppressed while the counter runs in a mode that uses the capture register as its TOP value.

Top module: `tic_capture_unit`

## Requirements
- R1: After reset, `cap_val_o` is 0, `cap_flag_o` is 0 and `irq_o` is 0.
- R2: With the filter off and `edge_rise_i`=1, a rising change of the selected trigger sets up a capture three clock edges later. If the change is applied before clock edge k, then at edge k+2 `cap_val_o` loads the `cnt_val_i` value present at that edge and `cap_flag_o` goes to 1. At edge k+1 the flag is still 0.
- R3: With `edge_rise_i`=0 only falling changes capture, with the same latency as R2. Rising changes leave the flag at 0.
- R4: `src_sel_i`=0 selects `cap_pin_i` and `src_sel_i`=1 selects `cmp_out_i`. Changes on the unselected input cause no capture.
- R5: Switching `src_sel_i` between inputs that carry different levels looks like an edge of the selected trigger. It captures when the resulting transition matches the edge polarity, with R2 latency counted from the switch.
- R6: With `filt_en_i`=1, a clean transition is captured exactly four clock edges later than with the filter off, at edge k+6.
- R7: With `filt_en_i`=1, a pulse on the trigger lasting three clock cycles causes no capture.
- R8: Every capture event overwrites `cap_val_o`, even while `cap_flag_o` is still 1.
- R9: A flag write (`clr_wr_i`=1) with `clr_bit_i`=1 clears `cap_flag_o` at the next edge. With `clr_bit_i`=0 the write leaves the flag unchanged.
- R10: If a capture event and a flag-clear write fall on the same clock edge, the capture wins. The flag stays 1 and the new value is stored.
- R11: `irq_o` is 1 exactly when `cap_flag_o` is 1 and `irq_en_i` is 1.
- R12: While `top_from_cap_i`=1, detected edges change neither `cap_val_o` nor `cap_flag_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_val_i | input | CNT_W | Value of the external free-running counter |
| cap_pin_i | input | 1 | External capture pin, asynchronous |
| cmp_out_i | input | 1 | Analog comparator output bit |
| src_sel_i | input | 1 | Trigger source: 0 = pin, 1 = comparator |
| filt_en_i | input | 1 | Enable the four-sample noise filter |
| edge_rise_i | input | 1 | Edge polarity: 1 = rising, 0 = falling |
| irq_en_i | input | 1 | Capture interrupt enable |
| top_from_cap_i | input | 1 | Counter mode uses the capture register as TOP; suppresses captures |
| clr_wr_i | input | 1 | Flag register write strobe |
| clr_bit_i | input | 1 | Data bit for the flag write; 1 clears the flag |
| cap_val_o | output | CNT_W | Captured counter value |
| cap_flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Capture interrupt request |

## Verification
A capture event and a software write that clears the flag can land on the same clock edge, and the flag register has to settle that conflict. The bench brings about this collision in two steps. It first leaves the flag set. Then it raises the pin and times the clear strobe so that the strobe is held across exactly the edge where the synchronized edge is captured, counted as two edges after the pin change. The outcome is judged at the ports: the flag must still read 1 and the capture register must hold the counter value of that edge. A separate scenario checks that a lone clear write does drop the flag.

// File: rtl/tic_pkg.sv
package tic_pkg;
  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;
endpackage

// File: rtl/tic_sync.sv
module tic_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tic_filter.sv
module tic_filter #(
  parameter int unsigned SAMPLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned HIST_W = SAMPLES - 1;

  logic [HIST_W-1:0]  hist_q;
  logic [SAMPLES-1:0] win;
  logic               out_q;

  assign win = {hist_q, d_i};

  // output moves only when the whole window agrees
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      out_q  <= 1'b0;
    end else begin
      hist_q <= win[HIST_W-1:0];
      if (&win)       out_q <= 1'b1;
      else if (~|win) out_q <= 1'b0;
    end
  end

  assign q_o = out_q;
endmodule

// File: rtl/tic_edge_det.sv
module tic_edge_det
  import tic_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      d_i,
  input  edge_pol_e pol_i,
  output logic      hit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= d_i;
  end

  always_comb begin
    unique case (pol_i)
      EDGE_RISE: hit_o = d_i & ~prev_q;
      default:   hit_o = ~d_i & prev_q;
    endcase
  end
endmodule

// File: rtl/tic_capture_unit.sv
module tic_capture_unit
  import tic_pkg::*;
#(
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned FILT_SAMPLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic             cap_pin_i,
  input  logic             cmp_out_i,
  input  logic             src_sel_i,
  input  logic             filt_en_i,
  input  logic             edge_rise_i,
  input  logic             irq_en_i,
  input  logic             top_from_cap_i,
  input  logic             clr_wr_i,
  input  logic             clr_bit_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_flag_o,
  output logic             irq_o
);
  logic trig_raw, trig_s, trig_f, trig_e, edge_hit, cap_evt;
  logic [CNT_W-1:0] cap_val_q;
  logic flag_q;

  // source mux ahead of the synchronizer: a switch looks like an edge
  assign trig_raw = src_sel_i ? cmp_out_i : cap_pin_i;

  tic_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (trig_raw),
    .q_o   (trig_s)
  );

  generate
    if (FILT_SAMPLES > 1) begin : g_filt
      tic_filter #(.SAMPLES(FILT_SAMPLES)) filt_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (trig_s),
        .q_o   (trig_f)
      );
    end else begin : g_nofilt
      assign trig_f = trig_s;
    end
  endgenerate

  assign trig_e = filt_en_i ? trig_f : trig_s;

  tic_edge_det edge_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (trig_e),
    .pol_i (edge_pol_e'(edge_rise_i)),
    .hit_o (edge_hit)
  );

  assign cap_evt = edge_hit & ~top_from_cap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_val_q <= '0;
      flag_q    <= 1'b0;
    end else begin
      if (cap_evt) cap_val_q <= cnt_val_i;
      // set beats clear on collision
      if (cap_evt)                    flag_q <= 1'b1;
      else if (clr_wr_i && clr_bit_i) flag_q <= 1'b0;
    end
  end

  assign cap_val_o  = cap_val_q;
  assign cap_flag_o = flag_q;
  assign irq_o      = flag_q & irq_en_i;
endmodule

// File: rtl/tic_capture_chk.sv
module tic_capture_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             top_from_cap_i,
  input logic             clr_wr_i,
  input logic             clr_bit_i,
  input logic [CNT_W-1:0] cap_val_o,
  input logic             cap_flag_o,
  input logic             irq_o
);
  // R11
  irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cap_flag_o);

  // R8
  new_value_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cap_val_o) |-> cap_flag_o);

  // R12
  top_mode_holds_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    top_from_cap_i |=> $stable(cap_val_o));

  // R12
  top_mode_no_flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (top_from_cap_i && !cap_flag_o) |=> !cap_flag_o);

  // R9
  clear_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && clr_bit_i && top_from_cap_i) |=> !cap_flag_o);

  // R9
  clear_zero_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && !clr_bit_i && cap_flag_o) |=> cap_flag_o);
endmodule

bind tic_capture_unit tic_capture_chk #(.CNT_W(CNT_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .top_from_cap_i(top_from_cap_i),
  .clr_wr_i      (clr_wr_i),
  .clr_bit_i     (clr_bit_i),
  .cap_val_o     (cap_val_o),
  .cap_flag_o    (cap_flag_o),
  .irq_o         (irq_o)
);

// File: tb/tic_capture_unit_tb_top.sv
`timescale 1ns/1ps
module tic_capture_unit_tb_top;
  localparam int unsigned CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] cnt_q;
  logic pin = 0, cmp = 0, src = 0, filt = 0, rise = 1, irq_en = 0, top = 0;
  logic clr_wr = 0, clr_bit = 0;
  logic [CNT_W-1:0] cap_val;
  logic cap_flag, irq;

  int vecs = 0;
  int errs = 0;

  always #2 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= 16'h1230;
    else        cnt_q <= cnt_q + 16'd1;
  end

  tic_capture_unit #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_val_i(cnt_q),
    .cap_pin_i(pin), .cmp_out_i(cmp), .src_sel_i(src), .filt_en_i(filt),
    .edge_rise_i(rise), .irq_en_i(irq_en), .top_from_cap_i(top),
    .clr_wr_i(clr_wr), .clr_bit_i(clr_bit),
    .cap_val_o(cap_val), .cap_flag_o(cap_flag), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_flag();
    clr_wr = 1; clr_bit = 1;
    step(1);
    clr_wr = 0; clr_bit = 0;
  endtask

  task automatic t_reset();
    irq_en = 1; #1;
    chk("R1 cap_val", cap_val, 0);
    chk("R1 flag", cap_flag, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_rise();
    logic [CNT_W-1:0] v;
    rise = 1; pin = 1; v = cnt_q;
    step(2);
    chk("R2 flag before", cap_flag, 0);
    step(1);
    chk("R2 flag", cap_flag, 1);
    chk("R2 value", cap_val, v + 16'd2);
    pin = 0; step(4); clear_flag();
  endtask

  task automatic t_fall();
    logic [CNT_W-1:0] v;
    rise = 0; pin = 1;
    step(6);
    chk("R3 rising ignored", cap_flag, 0);
    pin = 0; v = cnt_q;
    step(3);
    chk("R3 flag", cap_flag, 1);
    chk("R3 value", cap_val, v + 16'd2);
    clear_flag(); rise = 1; step(2);
  endtask

  task automatic t_source();
    logic [CNT_W-1:0] v;
    src = 0; cmp = 1;
    step(6);
    chk("R4 unselected ignored", cap_flag, 0);
    src = 1; v = cnt_q;
    step(3);
    chk("R5 switch flag", cap_flag, 1);
    chk("R5 switch value", cap_val, v + 16'd2);
    cmp = 0; step(4); src = 0; step(2); clear_flag();
  endtask

  task automatic t_filter();
    logic [CNT_W-1:0] v;
    filt = 1; step(2);
    pin = 1; v = cnt_q;
    step(6);
    chk("R6 flag before", cap_flag, 0);
    step(1);
    chk("R6 flag", cap_flag, 1);
    chk("R6 value", cap_val, v + 16'd6);
    pin = 0; step(8); clear_flag();
  endtask

  task automatic t_glitch();
    pin = 1; step(3); pin = 0;
    step(10);
    chk("R7 short pulse", cap_flag, 0);
    filt = 0; step(2);
  endtask

  task automatic t_overwrite();
    logic [CNT_W-1:0] v1, v2;
    pin = 1; v1 = cnt_q; step(3);
    chk("R8 first", cap_val, v1 + 16'd2);
    pin = 0; step(3);
    pin = 1; v2 = cnt_q; step(3);
    chk("R8 overwrite value", cap_val, v2 + 16'd2);
    chk("R8 flag", cap_flag, 1);
    pin = 0; step(3);
  endtask

  task automatic t_clear();
    clr_wr = 1; clr_bit = 0; step(1); clr_wr = 0;
    chk("R9 zero write", cap_flag, 1);
    clear_flag();
    chk("R9 one write", cap_flag, 0);
  endtask

  task automatic t_irq();
    irq_en = 0;
    pin = 1; step(3); pin = 0; #1;
    chk("R11 flag set", cap_flag, 1);
    chk("R11 irq masked", irq, 0);
    irq_en = 1; #1;
    chk("R11 irq on", irq, 1);
    step(3); clear_flag(); #1;
    chk("R11 irq off", irq, 0);
  endtask

  task automatic t_collide();
    logic [CNT_W-1:0] v;
    pin = 1; step(3); pin = 0; step(3);
    pin = 1; v = cnt_q;
    step(2);
    clr_wr = 1; clr_bit = 1;
    step(1);
    clr_wr = 0; clr_bit = 0;
    chk("R10 flag kept", cap_flag, 1);
    chk("R10 value", cap_val, v + 16'd2);
    pin = 0; step(3); clear_flag();
  endtask

  task automatic t_top();
    logic [CNT_W-1:0] prev;
    top = 1; prev = cap_val;
    pin = 1; step(5);
    chk("R12 flag", cap_flag, 0);
    chk("R12 value", cap_val, prev);
    pin = 0; step(4); top = 0; step(1);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(2);
    t_reset();
    t_rise();
    t_fall();
    t_source();
    t_filter();
    t_glitch();
    t_overwrite();
    t_clear();
    t_irq();
    t_collide();
    t_top();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #800000;
    errs++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule